// File: doc/BRIEF.md
# ACPI Sleep State Controller

This block is the power-management sequencer that moves the chip between a working state and four graded sleep levels: a light S1 level, a deep S1 level, S3, and a combined S4/S5 level. Software requests entry by writing a 2-bit level code with a one-cycle write strobe. The controller first asks the SDRAM controller to enter self-refresh and waits for its acknowledge. It then stops the clocks that the chosen level requires, and only after that drops the power-control outputs. The level decides whether the processor clock alone stops, whether the PLLs stop, whether some PLL-derived clocks stay alive, which of the two power-control outputs fall, and whether the active-low main power-on output is released.

Wake events arrive as a vector. Each level has its own capability mask, so a deeper level listens to fewer sources. On an accepted wake, power is restored before clocks, and self-refresh is released last. Leaving either S1 level is a context-kept resume, marked by a one-cycle resume pulse. Leaving S3 or S4/S5 runs a power-up sequence, during which a system reset output is held for a programmed time. A bus-master request in the light S1 level causes a temporary exit. The level is entered again once the master is done.

The free-running 32 kHz clock output keeps toggling in every state. In S4/S5 an active-low LED can show the sleep state. Its behaviour is set by a 2-bit field, bits [7:6] of a function-control register.

Top module: `sleep_state_ctrl`

## Requirements
- R1: After reset the block is in the working state: cpu_clk_stop=0, pll_en=1, clk_gate_en all ones, sr_req=0, pwr_a_on=1, pwr_b_on=1, main_on_n=0, led_n=1, sys_reset=0.
- R2: Level code 00 (light S1): cpu_clk_stop=1, sr_req=1, pll_en=1, clk_gate_en all ones, both power-control outputs 1, main_on_n=0.
- R3: Level code 01 (deep S1): cpu_clk_stop=1, sr_req=1, clk_gate_en equals keep_clk, pll_en=1 only when keep_clk is nonzero, pwr_a_on=0, pwr_b_on=1, main_on_n=0.
- R4: Ordering. cpu_clk_stop rises only after sr_ack was seen high. A power-control output falls only while the processor clock is already stopped. Whenever the processor clock runs, both power-control outputs are 1 and main_on_n is 0.
- R5: Waking from either S1 level gives exactly one ctx_resume pulse and no sys_reset cycle, and ends in the working state.
- R6: Level code 10 (S3): cpu_clk_stop=1, sr_req=1, pll_en=0, clk_gate_en all zeros, pwr_a_on=0, pwr_b_on=0, main_on_n=0.
- R7: Waking from S3 or S4/S5 holds sys_reset for at least PWRUP_CYC cycles, gives no ctx_resume pulse, and ends in the working state.
- R8: wake_evt bit i is accepted only if bit i of the current level's mask is set. The default masks are light S1 8'hFF, deep S1 8'h3F, S3 8'h0F, S4/S5 8'h07. A masked event leaves the sleep outputs unchanged.
- R9: In light S1, busm_req high gives cpu_clk_stop=0 and sr_req=0 while it lasts. Once it drops, the controller returns to the light S1 outputs.
- R10: A sleep write while not in the working state is ignored. The outputs of the current level stay unchanged.
- R11: Level code 11 (S4/S5): like S3 but main_on_n=1. While sleeping there, led_sel 00 gives led_n=1, 01 gives led_n=0, 10 toggles led_n every SLOW_T ticks, and 11 toggles it every FAST_T ticks. led_n is 1 outside S4/S5 sleep.
- R12: clk32_out toggles once on every tick32 pulse, in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick32 | input | 1 | One-cycle pulse per 32 kHz period |
| slp_wr | input | 1 | Sleep request write strobe |
| slp_lvl | input | 2 | Requested level: 00 light S1, 01 deep S1, 10 S3, 11 S4/S5 |
| fc_wr | input | 1 | Function-control write strobe |
| led_sel | input | 2 | LED field, bits [7:6] of the function-control register |
| keep_clk | input | NCLK | PLL-derived clocks kept alive in deep S1 |
| wake_evt | input | NW | Wake event sources |
| busm_req | input | 1 | Bus-master request |
| sr_ack | input | 1 | SDRAM self-refresh acknowledge |
| cpu_clk_stop | output | 1 | Stop processor, memory and display controller clocks |
| pll_en | output | 1 | PLL run enable |
| clk_gate_en | output | NCLK | Per-clock gating enables |
| sr_req | output | 1 | SDRAM self-refresh request |
| pwr_a_on | output | 1 | Power-control output 1 (active high) |
| pwr_b_on | output | 1 | Power-control output 2 (active high) |
| main_on_n | output | 1 | Main power-on, active low |
| led_n | output | 1 | Status LED, active low |
| clk32_out | output | 1 | 32 kHz clock output |
| sys_reset | output | 1 | Reset held during the power-up sequence |
| ctx_resume | output | 1 | One-cycle pulse on a context-kept resume |

## Verification
The ordering assertions rely on sr_ack behaving as a true handshake: it rises only after sr_req rises and falls only after sr_req falls. The bench models it as a two-cycle follower of sr_req. The toggle and blink checks assume tick32 is a single-cycle pulse, and the bench makes one every eighth clock. Wake events and bus-master requests are held for several cycles and are removed before the next phase. Sleep writes are single-cycle strobes, so no request overlaps an unfinished transition the bench does not intend to test.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  typedef enum logic [1:0] {
    LV_LIGHT = 2'b00,
    LV_DEEP  = 2'b01,
    LV_S3    = 2'b10,
    LV_S45   = 2'b11
  } slp_lvl_e;

  typedef enum logic [3:0] {
    ST_WORK,
    ST_SR_WAIT,
    ST_CLK_OFF,
    ST_PWR_OFF,
    ST_SLEEP,
    ST_BM_SVC,
    ST_PWR_ON,
    ST_CLK_ON,
    ST_SR_EXIT
  } slp_st_e;

  function automatic logic keeps_context(slp_lvl_e l);
    return (l == LV_LIGHT) || (l == LV_DEEP);
  endfunction

endpackage

// File: rtl/sleep_wake_filter.sv
module sleep_wake_filter
  import sleep_pkg::*;
#(
  parameter int NW = 8,
  parameter logic [NW-1:0] CAP_LIGHT = '1,
  parameter logic [NW-1:0] CAP_DEEP  = '1,
  parameter logic [NW-1:0] CAP_S3    = '1,
  parameter logic [NW-1:0] CAP_S45   = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] evt,
  input  slp_lvl_e      lvl,
  output logic          hit_q
);

  logic [NW-1:0] mask;

  always_comb begin
    unique case (lvl)
      LV_LIGHT: mask = CAP_LIGHT;
      LV_DEEP:  mask = CAP_DEEP;
      LV_S3:    mask = CAP_S3;
      LV_S45:   mask = CAP_S45;
      default:  mask = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= |(evt & mask);
  end

  // R8: an accepted wake always traces back to some raised source
  a_r8_hit_needs_evt: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(|evt));

endmodule

// File: rtl/sleep_led_blink.sv
module sleep_led_blink #(
  parameter int SLOW_T = 16,
  parameter int FAST_T = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       active,
  input  logic       mode_wr,
  input  logic [1:0] mode_in,
  output logic       led_n
);

  localparam int BW = $clog2(SLOW_T + 1);
  localparam logic [BW-1:0] SLOW_LAST = BW'(SLOW_T - 1);
  localparam logic [BW-1:0] FAST_LAST = BW'(FAST_T - 1);

  logic [1:0]    mode_q;
  logic [BW-1:0] cnt;
  logic [BW-1:0] lim;
  logic          phase;
  logic          led_nxt;

  assign lim = mode_q[0] ? FAST_LAST : SLOW_LAST;

  always_comb begin
    if (!active) led_nxt = 1'b1;
    else begin
      unique case (mode_q)
        2'b00:   led_nxt = 1'b1;
        2'b01:   led_nxt = 1'b0;
        default: led_nxt = ~phase;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 2'b00;
      cnt    <= '0;
      phase  <= 1'b0;
      led_n  <= 1'b1;
    end else begin
      if (mode_wr) mode_q <= mode_in;
      if (!active) begin
        cnt   <= '0;
        phase <= 1'b0;
      end else if (tick) begin
        if (cnt >= lim) begin
          cnt   <= '0;
          phase <= ~phase;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      led_n <= led_nxt;
    end
  end

  // R11: the LED lights only while the S4/S5 sleep was active
  a_r11_led_only_s45: assert property (@(posedge clk) disable iff (rst)
    !led_n |-> $past(active));

endmodule

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
  import sleep_pkg::*;
#(
  parameter int NCLK      = 4,
  parameter int PWRUP_CYC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slp_wr,
  input  logic [1:0]      slp_lvl_in,
  input  logic            sr_ack,
  input  logic            wake_hit,
  input  logic            busm_req,
  input  logic [NCLK-1:0] keep_clk,
  output slp_lvl_e        lvl,
  output logic            cpu_clk_stop,
  output logic            pll_en,
  output logic [NCLK-1:0] clk_gate_en,
  output logic            sr_req,
  output logic            pwr_a_on,
  output logic            pwr_b_on,
  output logic            main_on_n,
  output logic            sys_reset,
  output logic            ctx_resume,
  output logic            s45_sleep
);

  localparam int CW = $clog2(PWRUP_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(PWRUP_CYC - 1);

  slp_st_e       st, nxt;
  slp_lvl_e      lvl_n;
  logic [CW-1:0] cnt, cnt_n;

  // next-state decode
  always_comb begin
    nxt   = st;
    lvl_n = lvl;
    cnt_n = cnt;
    unique case (st)
      ST_WORK: if (slp_wr) begin
        lvl_n = slp_lvl_e'(slp_lvl_in);
        nxt   = ST_SR_WAIT;
      end
      ST_SR_WAIT: if (sr_ack) nxt = ST_CLK_OFF;
      ST_CLK_OFF: nxt = ST_PWR_OFF;
      ST_PWR_OFF: nxt = ST_SLEEP;
      ST_SLEEP: begin
        if (wake_hit) begin
          nxt   = ST_PWR_ON;
          cnt_n = '0;
        end else if (lvl == LV_LIGHT && busm_req) begin
          nxt = ST_BM_SVC;
        end
      end
      ST_BM_SVC: if (!busm_req && !sr_ack) nxt = ST_SR_WAIT;
      ST_PWR_ON: begin
        if (keeps_context(lvl) || cnt == CNT_LAST) nxt = ST_CLK_ON;
        else cnt_n = cnt + 1'b1;
      end
      ST_CLK_ON:  nxt = ST_SR_EXIT;
      ST_SR_EXIT: if (!sr_ack) nxt = ST_WORK;
      default:    nxt = ST_WORK;
    endcase
  end

  // output pattern for the state being entered
  logic            clk_off_ph, pwr_off_ph, deep_clk;
  logic            o_pll, o_sr, o_pa, o_pb, o_mon_n, o_rst, o_res;
  logic [NCLK-1:0] o_gate;

  always_comb begin
    clk_off_ph = nxt inside {ST_CLK_OFF, ST_PWR_OFF, ST_SLEEP, ST_PWR_ON};
    pwr_off_ph = nxt inside {ST_PWR_OFF, ST_SLEEP};
    deep_clk   = (lvl_n != LV_LIGHT);
    o_pll      = !(clk_off_ph && deep_clk) || (lvl_n == LV_DEEP && |keep_clk);
    if (!clk_off_ph || lvl_n == LV_LIGHT) o_gate = '1;
    else if (lvl_n == LV_DEEP)            o_gate = keep_clk;
    else                                  o_gate = '0;
    o_sr    = nxt inside {ST_SR_WAIT, ST_CLK_OFF, ST_PWR_OFF, ST_SLEEP,
                          ST_PWR_ON, ST_CLK_ON};
    o_pa    = !(pwr_off_ph && lvl_n != LV_LIGHT);
    o_pb    = !(pwr_off_ph && (lvl_n == LV_S3 || lvl_n == LV_S45));
    o_mon_n = pwr_off_ph && lvl_n == LV_S45;
    o_rst   = (nxt inside {ST_PWR_ON, ST_CLK_ON, ST_SR_EXIT}) && !keeps_context(lvl_n);
    o_res   = (st == ST_SR_EXIT) && (nxt == ST_WORK) && keeps_context(lvl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_WORK;
      lvl          <= LV_LIGHT;
      cnt          <= '0;
      cpu_clk_stop <= 1'b0;
      pll_en       <= 1'b1;
      clk_gate_en  <= '1;
      sr_req       <= 1'b0;
      pwr_a_on     <= 1'b1;
      pwr_b_on     <= 1'b1;
      main_on_n    <= 1'b0;
      sys_reset    <= 1'b0;
      ctx_resume   <= 1'b0;
      s45_sleep    <= 1'b0;
    end else begin
      st           <= nxt;
      lvl          <= lvl_n;
      cnt          <= cnt_n;
      cpu_clk_stop <= clk_off_ph;
      pll_en       <= o_pll;
      clk_gate_en  <= o_gate;
      sr_req       <= o_sr;
      pwr_a_on     <= o_pa;
      pwr_b_on     <= o_pb;
      main_on_n    <= o_mon_n;
      sys_reset    <= o_rst;
      ctx_resume   <= o_res;
      s45_sleep    <= (nxt == ST_SLEEP) && (lvl_n == LV_S45);
    end
  end

  // R4: clocks stop only once self-refresh has been acknowledged
  a_r4_sr_before_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk_stop) |-> $past(sr_ack));

  // R4: power output 1 falls only after the processor clock is already stopped
  a_r4_clk_before_pwr: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_a_on) |-> $past(cpu_clk_stop));

  // R4: a running processor clock always has full power behind it
  a_r4_run_needs_power: assert property (@(posedge clk) disable iff (rst)
    !cpu_clk_stop |-> (pwr_a_on && pwr_b_on && !main_on_n));

  // R5: a context-kept level never drives the power-up reset
  a_r5_no_reset_shallow: assert property (@(posedge clk) disable iff (rst)
    sys_reset |-> !keeps_context(lvl));

  // R7: the power-up reset and the resume pulse never coincide
  a_r7_reset_xor_resume: assert property (@(posedge clk) disable iff (rst)
    !(sys_reset && ctx_resume));

endmodule

// File: rtl/sleep_state_ctrl.sv
module sleep_state_ctrl
  import sleep_pkg::*;
#(
  parameter int NW        = 8,
  parameter int NCLK      = 4,
  parameter int PWRUP_CYC = 16,
  parameter int SLOW_T    = 16,
  parameter int FAST_T    = 4,
  parameter logic [NW-1:0] CAP_LIGHT = 8'hFF,
  parameter logic [NW-1:0] CAP_DEEP  = 8'h3F,
  parameter logic [NW-1:0] CAP_S3    = 8'h0F,
  parameter logic [NW-1:0] CAP_S45   = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick32,
  input  logic            slp_wr,
  input  logic [1:0]      slp_lvl,
  input  logic            fc_wr,
  input  logic [1:0]      led_sel,
  input  logic [NCLK-1:0] keep_clk,
  input  logic [NW-1:0]   wake_evt,
  input  logic            busm_req,
  input  logic            sr_ack,
  output logic            cpu_clk_stop,
  output logic            pll_en,
  output logic [NCLK-1:0] clk_gate_en,
  output logic            sr_req,
  output logic            pwr_a_on,
  output logic            pwr_b_on,
  output logic            main_on_n,
  output logic            led_n,
  output logic            clk32_out,
  output logic            sys_reset,
  output logic            ctx_resume
);

  slp_lvl_e cur_lvl;
  logic     wake_hit;
  logic     s45_sleep;

  sleep_wake_filter #(
    .NW(NW), .CAP_LIGHT(CAP_LIGHT), .CAP_DEEP(CAP_DEEP),
    .CAP_S3(CAP_S3), .CAP_S45(CAP_S45)
  ) u_filt (
    .clk(clk), .rst(rst), .evt(wake_evt), .lvl(cur_lvl), .hit_q(wake_hit)
  );

  sleep_seq_fsm #(.NCLK(NCLK), .PWRUP_CYC(PWRUP_CYC)) u_fsm (
    .clk(clk), .rst(rst), .slp_wr(slp_wr), .slp_lvl_in(slp_lvl),
    .sr_ack(sr_ack), .wake_hit(wake_hit), .busm_req(busm_req),
    .keep_clk(keep_clk), .lvl(cur_lvl), .cpu_clk_stop(cpu_clk_stop),
    .pll_en(pll_en), .clk_gate_en(clk_gate_en), .sr_req(sr_req),
    .pwr_a_on(pwr_a_on), .pwr_b_on(pwr_b_on), .main_on_n(main_on_n),
    .sys_reset(sys_reset), .ctx_resume(ctx_resume), .s45_sleep(s45_sleep)
  );

  sleep_led_blink #(.SLOW_T(SLOW_T), .FAST_T(FAST_T)) u_led (
    .clk(clk), .rst(rst), .tick(tick32), .active(s45_sleep),
    .mode_wr(fc_wr), .mode_in(led_sel), .led_n(led_n)
  );

  // slow clock output lives outside all sleep gating
  always_ff @(posedge clk) begin
    if (rst)         clk32_out <= 1'b0;
    else if (tick32) clk32_out <= ~clk32_out;
  end

  // R12: every tick flips the slow clock output
  a_r12_clk32_toggle: assert property (@(posedge clk) disable iff (rst)
    tick32 |=> (clk32_out != $past(clk32_out)));

endmodule

// File: tb/sleep_state_ctrl_test.sv
module sleep_state_ctrl_test;

  localparam int CLK_NS = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick32 = 1'b0;
  logic [2:0] tdiv = '0;
  logic       slp_wr = 1'b0;
  logic [1:0] slp_lvl = '0;
  logic       fc_wr = 1'b0;
  logic [1:0] led_sel = '0;
  logic [3:0] keep_clk = '0;
  logic [7:0] wake_evt = '0;
  logic       busm_req = 1'b0;
  logic       sr_ack;
  logic [1:0] ack_pipe = '0;
  logic       cpu_clk_stop, pll_en, sr_req, pwr_a_on, pwr_b_on, main_on_n;
  logic       led_n, clk32_out, sys_reset, ctx_resume;
  logic [3:0] clk_gate_en;

  int total = 0, bad = 0;
  int resume_cnt = 0, rst_cycles = 0, led_tog = 0, c32_tog = 0, order_bad = 0;
  bit done = 0;

  string      tq[$];
  logic [9:0] vq[$];

  always #(CLK_NS / 2.0) clk = ~clk;

  // self-refresh acknowledge follows the request by two cycles
  always @(posedge clk) begin
    ack_pipe <= {ack_pipe[0], sr_req};
    tdiv     <= tdiv + 1'b1;
    tick32   <= (tdiv == 3'd7);
  end
  assign sr_ack = ack_pipe[1];

  sleep_state_ctrl uut (
    .clk(clk), .rst(rst), .tick32(tick32), .slp_wr(slp_wr), .slp_lvl(slp_lvl),
    .fc_wr(fc_wr), .led_sel(led_sel), .keep_clk(keep_clk), .wake_evt(wake_evt),
    .busm_req(busm_req), .sr_ack(sr_ack), .cpu_clk_stop(cpu_clk_stop),
    .pll_en(pll_en), .clk_gate_en(clk_gate_en), .sr_req(sr_req),
    .pwr_a_on(pwr_a_on), .pwr_b_on(pwr_b_on), .main_on_n(main_on_n),
    .led_n(led_n), .clk32_out(clk32_out), .sys_reset(sys_reset),
    .ctx_resume(ctx_resume)
  );

  function automatic logic [9:0] mkv(logic cpu, logic pll, logic [3:0] g,
                                     logic sr, logic pa, logic pb, logic mon);
    return {cpu, pll, g, sr, pa, pb, mon};
  endfunction

  localparam logic [9:0] V_WORK  = {1'b0, 1'b1, 4'hF, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [9:0] V_LIGHT = {1'b1, 1'b1, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0};

  // monitor: pops expected items and watches ordering and counters
  logic p_cpu = 1'b0, p_pa = 1'b1, p_ack = 1'b0, p_led = 1'b1, p_c32 = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (tq.size() > 0) begin
        string      t;
        logic [9:0] e, a;
        t = tq.pop_front();
        e = vq.pop_front();
        a = {cpu_clk_stop, pll_en, clk_gate_en, sr_req, pwr_a_on, pwr_b_on, main_on_n};
        total++;
        if (a !== e) begin
          bad++;
          $display("FAIL %s actual=%b expected=%b", t, a, e);
        end
      end
      if (!rst) begin
        if (ctx_resume) resume_cnt++;
        if (sys_reset) rst_cycles++;
        if (led_n != p_led) led_tog++;
        if (clk32_out != p_c32) c32_tog++;
        if (p_pa && !pwr_a_on && !p_cpu) order_bad++;
        if (p_cpu && !cpu_clk_stop && !(pwr_a_on && pwr_b_on)) order_bad++;
        if (!p_cpu && cpu_clk_stop && !p_ack) order_bad++;
      end
      p_cpu = cpu_clk_stop; p_pa = pwr_a_on; p_ack = sr_ack;
      p_led = led_n; p_c32 = clk32_out;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_v(input string t, input logic [9:0] v);
    tq.push_back(t);
    vq.push_back(v);
    cyc(1);
  endtask

  task automatic chk(input string t, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic chk_rng(input string t, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", t, act, lo, hi);
    end
  endtask

  task automatic enter(input logic [1:0] l);
    slp_lvl = l; slp_wr = 1'b1; cyc(1); slp_wr = 1'b0; cyc(12);
  endtask

  task automatic wake(input logic [7:0] m);
    wake_evt = m; cyc(3); wake_evt = '0;
  endtask

  task automatic set_led(input logic [1:0] m);
    led_sel = m; fc_wr = 1'b1; cyc(1); fc_wr = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    cyc(150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    cyc(5); rst = 1'b0; cyc(2);
    expect_v("R1 reset outputs", V_WORK);
    chk("R1 led_n after reset", int'(led_n), 1);
    chk("R1 sys_reset after reset", int'(sys_reset), 0);

    // light S1 and bus-master excursion
    enter(2'b00);
    expect_v("R2 light S1 outputs", V_LIGHT);
    busm_req = 1'b1; cyc(6);
    expect_v("R9 bus master service", mkv(0, 1, 4'hF, 0, 1, 1, 0));
    busm_req = 1'b0; cyc(15);
    expect_v("R9 back in light S1", V_LIGHT);
    resume_cnt = 0; rst_cycles = 0;
    wake(8'h80); cyc(15);
    expect_v("R5 light wake to work", V_WORK);
    chk("R5 resume pulses light", resume_cnt, 1);
    chk("R5 no reset light", rst_cycles, 0);

    // deep S1 with two clocks kept
    keep_clk = 4'b0101;
    enter(2'b01);
    expect_v("R3 deep S1 outputs", mkv(1, 1, 4'b0101, 1, 0, 1, 0));
    wake(8'h80); cyc(15);
    expect_v("R8 masked source in deep S1", mkv(1, 1, 4'b0101, 1, 0, 1, 0));
    slp_lvl = 2'b11; slp_wr = 1'b1; cyc(1); slp_wr = 1'b0; cyc(10);
    expect_v("R10 write ignored while asleep", mkv(1, 1, 4'b0101, 1, 0, 1, 0));
    resume_cnt = 0; rst_cycles = 0;
    wake(8'h20); cyc(15);
    expect_v("R5 deep wake to work", V_WORK);
    chk("R5 resume pulses deep", resume_cnt, 1);
    chk("R5 no reset deep", rst_cycles, 0);

    // S3
    keep_clk = 4'b0000;
    enter(2'b10);
    expect_v("R6 S3 outputs", mkv(1, 0, 4'h0, 1, 0, 0, 0));
    wake(8'h10); cyc(15);
    expect_v("R8 masked source in S3", mkv(1, 0, 4'h0, 1, 0, 0, 0));
    resume_cnt = 0; rst_cycles = 0;
    wake(8'h08); cyc(40);
    expect_v("R7 S3 wake to work", V_WORK);
    chk_rng("R7 reset length S3", rst_cycles, 16, 40);
    chk("R7 no resume pulse S3", resume_cnt, 0);

    // S4/S5 with LED modes
    set_led(2'b01);
    enter(2'b11);
    expect_v("R11 S4/S5 outputs", mkv(1, 0, 4'h0, 1, 0, 0, 1));
    chk("R11 led on mode", int'(led_n), 0);
    c32_tog = 0; cyc(160);
    chk_rng("R12 clk32 toggles", c32_tog, 19, 21);
    set_led(2'b10); cyc(2);
    led_tog = 0; cyc(512);
    chk_rng("R11 slow blink toggles", led_tog, 3, 6);
    set_led(2'b11); cyc(2);
    led_tog = 0; cyc(512);
    chk_rng("R11 fast blink toggles", led_tog, 15, 18);
    set_led(2'b00); cyc(3);
    chk("R11 led off mode", int'(led_n), 1);
    set_led(2'b01); cyc(3);
    wake(8'h08); cyc(15);
    expect_v("R8 masked source in S4/S5", mkv(1, 0, 4'h0, 1, 0, 0, 1));
    resume_cnt = 0; rst_cycles = 0;
    wake(8'h04); cyc(40);
    expect_v("R7 S4/S5 wake to work", V_WORK);
    chk_rng("R7 reset length S4/S5", rst_cycles, 16, 40);
    chk("R7 no resume pulse S4/S5", resume_cnt, 0);
    chk("R11 led dark when working", int'(led_n), 1);
    chk("R4 sequencing order", order_bad, 0);
    cyc(3);
    finish_run();
  end

endmodule